// File: doc/BRIEF.md
# Channel hit readout sequencer

This block runs the readout of one front-end channel. A hit arrives on an input that is not tied to the clock. The block brings it into the clock domain, raises a one-cycle sample strobe a programmable number of cycles later, and then resets the front-end stages.

The reset lines are the preamplifier, the shaper, and a third line shared by the peak hold and the channel logic. All three go high together in the cycle after the strobe. They then drop one at a time in a fixed order, and the last one is held for a programmable number of extra cycles.

The sample delay and the extra hold come straight from ports. Both are captured when a hit is detected, so each readout runs with the values present at its start. The busy output covers the whole readout. Hits that arrive while it is high are dropped.

Top module: `hit_seq_top`

## Requirements
In these requirements, edge k is the first rising clock edge at which `hit_in` is sampled high after being low. E = k+2 is the detection edge. N is `sample_dly` captured at E, raised to 2 if it is lower. X is `extra_hold` captured at E. A = E+N+1 is the edge at which the resets assert.

- R1: While `rst` is high, and after it, until a hit is detected, `sample_stb`, `rst_preamp`, `rst_shaper`, `rst_core` and `busy` are all 0.
- R2: `busy` goes high at edge E, two edges after the raw hit is first sampled, because of the two-flop synchroniser.
- R3: `sample_stb` is high for exactly one cycle, starting at edge E+N. It occurs once per readout.
- R4: A programmed `sample_dly` of 0 or 1 behaves as a delay of 2.
- R5: `rst_preamp`, `rst_shaper` and `rst_core` all go high together at edge A, the edge right after the strobe cycle.
- R6: `rst_preamp` goes low at edge A+2.
- R7: `rst_shaper` goes low at edge A+3.
- R8: `rst_core` goes low at edge A+4+X, and `busy` goes low at that same edge.
- R9: A hit that rises while `busy` is high starts no new readout, either during the current one or after it.
- R10: Changes to `sample_dly` or `extra_hold` after edge E do not alter the timing of the readout in progress.
- R11: A hit that stays high starts exactly one readout. A new readout needs the hit to go low and rise again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_in | input | 1 | Raw hit level from the channel, not synchronised to the clock |
| sample_dly | input | DLY_W | Cycles from detection to the strobe (values below 2 act as 2) |
| extra_hold | input | HOLD_W | Extra cycles added to the peak-hold and channel-logic reset |
| sample_stb | output | 1 | One-cycle sample-and-hold strobe |
| rst_preamp | output | 1 | Preamplifier reset |
| rst_shaper | output | 1 | Shaper reset |
| rst_core | output | 1 | Peak-hold and channel-logic reset |
| busy | output | 1 | High from detection until `rst_core` releases |

## Verification
The assertions assume the following about the inputs:
- `rst` is held for at least one edge before any check counts.
- The timing checks assume the block leaves reset in the idle state.

The stimulus keeps within this:
- It drives `hit_in` and the two count inputs only on falling edges, so every value is stable at the next rising edge.
- It uses counts small enough that each readout ends well inside the watchdog.
- It raises disturbing hits and count changes only while `busy` is high.
- It waits for `busy` to drop before it starts the next directed scenario, so the result of each scenario belongs to one readout.

// File: rtl/hit_seq_pkg.sv
package hit_seq_pkg;

    // Fixed timing of the staggered reset release, counted from the assert edge
    localparam int MIN_SAMPLE_DLY = 2;
    localparam int PREAMP_HOLD    = 2;
    localparam int SHAPER_HOLD    = 3;
    localparam int CORE_BASE_HOLD = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DELAY  = 2'd1,
        ST_STROBE = 2'd2,
        ST_RESET  = 2'd3
    } seq_state_e;

    // Raise a programmed delay to the allowed minimum
    function automatic int unsigned clamp_dly(input int unsigned v);
        return (v < MIN_SAMPLE_DLY) ? MIN_SAMPLE_DLY : v;
    endfunction

    // Terminal count of the reset phase (counter value seen on the release edge)
    function automatic int unsigned core_last(input int unsigned extra);
        return CORE_BASE_HOLD - 1 + extra;
    endfunction

endpackage

// File: rtl/hit_sync.sv
module hit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hit_in,
    output logic hit_rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= hit_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[STAGES-1];
    end

    assign hit_rise = chain[STAGES-1] & ~prev;

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import hit_seq_pkg::*;
#(
    parameter int DLY_W  = 8,
    parameter int HOLD_W = 8,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit_rise,
    input  logic [DLY_W-1:0]  sample_dly,
    input  logic [HOLD_W-1:0] extra_hold,
    output seq_state_e        state,
    output logic [CNT_W-1:0]  cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] dly_last;   // counter value on the edge that enters the strobe
        logic [CNT_W-1:0] core_last;  // counter value on the edge that releases the core reset
    } seq_cfg_t;

    seq_cfg_t cfg_q;
    seq_cfg_t cfg_new;

    always_comb begin
        cfg_new.dly_last  = CNT_W'(clamp_dly(32'(sample_dly)) - 1);
        cfg_new.core_last = CNT_W'(core_last(32'(extra_hold)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            cfg_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (hit_rise) begin
                        state <= ST_DELAY;
                        cfg_q <= cfg_new;
                    end
                end
                ST_DELAY: begin
                    if (cnt == cfg_q.dly_last) begin
                        state <= ST_STROBE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STROBE: begin
                    state <= ST_RESET;
                    cnt   <= '0;
                end
                ST_RESET: begin
                    if (cnt == cfg_q.core_last) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/rst_stagger.sv
module rst_stagger
    import hit_seq_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  seq_state_e       state,
    input  logic [CNT_W-1:0] cnt,
    output logic             sample_stb,
    output logic             rst_preamp,
    output logic             rst_shaper,
    output logic             rst_core,
    output logic             busy
);
    logic in_reset;

    always_comb begin
        in_reset   = (state == ST_RESET);
        sample_stb = (state == ST_STROBE);
        rst_preamp = in_reset && (cnt < CNT_W'(PREAMP_HOLD));
        rst_shaper = in_reset && (cnt < CNT_W'(SHAPER_HOLD));
        rst_core   = in_reset;
        busy       = (state != ST_IDLE);
    end

endmodule

// File: rtl/hit_seq_top.sv
module hit_seq_top
    import hit_seq_pkg::*;
#(
    parameter int DLY_W       = 8,
    parameter int HOLD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit_in,
    input  logic [DLY_W-1:0]  sample_dly,
    input  logic [HOLD_W-1:0] extra_hold,
    output logic              sample_stb,
    output logic              rst_preamp,
    output logic              rst_shaper,
    output logic              rst_core,
    output logic              busy
);
    localparam int MAX_W = (DLY_W > HOLD_W) ? DLY_W : HOLD_W;
    localparam int CNT_W = MAX_W + 2;

    logic             hit_rise;
    logic             hit_take;
    seq_state_e       state;
    logic [CNT_W-1:0] cnt;

    hit_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .hit_in   (hit_in),
        .hit_rise (hit_rise)
    );

    // A rising edge is taken only while idle; during a readout it is dropped
    assign hit_take = hit_rise & (state == ST_IDLE);

    seq_ctrl #(.DLY_W(DLY_W), .HOLD_W(HOLD_W), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .hit_rise   (hit_take),
        .sample_dly (sample_dly),
        .extra_hold (extra_hold),
        .state      (state),
        .cnt        (cnt)
    );

    rst_stagger #(.CNT_W(CNT_W)) u_stagger (
        .state      (state),
        .cnt        (cnt),
        .sample_stb (sample_stb),
        .rst_preamp (rst_preamp),
        .rst_shaper (rst_shaper),
        .rst_core   (rst_core),
        .busy       (busy)
    );

endmodule

// File: rtl/hit_seq_chk.sv
module hit_seq_chk (
    input logic clk,
    input logic rst,
    input logic sample_stb,
    input logic rst_preamp,
    input logic rst_shaper,
    input logic rst_core,
    input logic busy
);
    // R3
    strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> !sample_stb);

    // R3
    strobe_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> busy && !rst_core);

    // R5
    resets_follow_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> rst_preamp && rst_shaper && rst_core);

    // R5
    resets_rise_together_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_core) |-> rst_preamp && rst_shaper);

    // R6
    preamp_two_cycles_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_preamp) |=> rst_preamp ##1 !rst_preamp);

    // R7
    shaper_three_cycles_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_shaper) |=> rst_shaper ##1 rst_shaper ##1 !rst_shaper);

    // R7
    shaper_within_core_chk: assert property (@(posedge clk) disable iff (rst)
        rst_shaper |-> rst_core);

    // R6
    preamp_within_shaper_chk: assert property (@(posedge clk) disable iff (rst)
        rst_preamp |-> rst_shaper);

    // R8
    busy_ends_with_core_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $fell(rst_core));

    // R8
    core_only_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rst_core |-> busy);

endmodule

bind hit_seq_top hit_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sample_stb (sample_stb),
    .rst_preamp (rst_preamp),
    .rst_shaper (rst_shaper),
    .rst_core   (rst_core),
    .busy       (busy)
);

// File: tb/tb_hit_seq_top.sv
`timescale 1ns/1ps
module tb_hit_seq_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hit_in = 1'b0;
    logic [7:0] sample_dly = 8'd2;
    logic [7:0] extra_hold = 8'd0;
    logic       sample_stb, rst_preamp, rst_shaper, rst_core, busy;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hit_seq_top dut (
        .clk(clk), .rst(rst), .hit_in(hit_in),
        .sample_dly(sample_dly), .extra_hold(extra_hold),
        .sample_stb(sample_stb), .rst_preamp(rst_preamp),
        .rst_shaper(rst_shaper), .rst_core(rst_core), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk({sample_stb, rst_preamp, rst_shaper, rst_core, busy} == 5'b0,
            "R1 outputs in reset", {sample_stb, rst_preamp, rst_shaper, rst_core, busy}, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk({sample_stb, rst_preamp, rst_shaper, rst_core, busy} == 5'b0,
            "R1 outputs idle after reset", {sample_stb, rst_preamp, rst_shaper, rst_core, busy}, 0);
    endtask

    // One readout; hold keeps the hit high, disturb injects a hit and new counts mid-readout
    task automatic run_seq(input int n, input int x, input string tag,
                           input bit hold, input bit disturb);
        int k, en, e, a;
        int t_busy = -1, t_str = -1, n_str = 0, t_rr = -1;
        int t_pf = -1, t_sf = -1, t_kf = -1, t_bf = -1;
        int late = 0;
        bit rr_all = 1'b0;
        @(negedge clk);
        sample_dly = 8'(n);
        extra_hold = 8'(x);
        hit_in = 1'b1;
        k = cyc + 1;
        en = (n < 2) ? 2 : n;
        e = k + 2;
        a = e + en + 1;
        for (int i = 0; i < 600 && t_bf < 0; i++) begin
            @(negedge clk);
            if (i == 0 && !hold) hit_in = 1'b0;
            if (disturb && i == 4) begin
                hit_in = 1'b1;
                sample_dly = 8'd30;
                extra_hold = 8'd20;
            end
            if (disturb && i == 5) hit_in = 1'b0;
            if (busy && t_busy < 0) t_busy = cyc;
            if (sample_stb) begin
                n_str++;
                if (t_str < 0) t_str = cyc;
            end
            if (t_rr < 0 && (rst_preamp || rst_shaper || rst_core)) begin
                t_rr = cyc;
                rr_all = rst_preamp && rst_shaper && rst_core;
            end
            if (t_rr >= 0 && t_pf < 0 && !rst_preamp) t_pf = cyc;
            if (t_rr >= 0 && t_sf < 0 && !rst_shaper) t_sf = cyc;
            if (t_rr >= 0 && t_kf < 0 && !rst_core) t_kf = cyc;
            if (t_busy >= 0 && t_bf < 0 && !busy) t_bf = cyc;
        end
        chk(t_busy == e, {tag, " R2 busy rise"}, t_busy, e);
        chk(t_str == e + en, {tag, (n < 2) ? " R4 clamped strobe" : " R3 strobe time"}, t_str, e + en);
        chk(n_str == 1, {tag, " R3 strobe width"}, n_str, 1);
        chk(t_rr == a, {tag, " R5 reset assert"}, t_rr, a);
        chk(rr_all, {tag, " R5 resets together"}, rr_all, 1);
        chk(t_pf == a + 2, {tag, " R6 preamp release"}, t_pf, a + 2);
        chk(t_sf == a + 3, {tag, " R7 shaper release"}, t_sf, a + 3);
        chk(t_kf == a + 4 + x, {tag, " R8 core release"}, t_kf, a + 4 + x);
        chk(t_bf == a + 4 + x, {tag, " R8 busy fall"}, t_bf, a + 4 + x);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (busy || sample_stb) late++;
        end
        if (disturb) chk(late == 0, {tag, " R9 R10 no second readout"}, late, 0);
        if (hold)    chk(late == 0, {tag, " R11 held hit single readout"}, late, 0);
        if (!disturb && !hold) chk(late == 0, {tag, " R9 quiet after readout"}, late, 0);
        hit_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic test_min();     run_seq(2, 0, "min",     1'b0, 1'b0); endtask
    task automatic test_mid();     run_seq(5, 3, "mid",     1'b0, 1'b0); endtask
    task automatic test_clamp0();  run_seq(0, 1, "clamp0",  1'b0, 1'b0); endtask
    task automatic test_clamp1();  run_seq(1, 2, "clamp1",  1'b0, 1'b0); endtask
    task automatic test_disturb(); run_seq(4, 2, "disturb", 1'b0, 1'b1); endtask
    task automatic test_hold();    run_seq(3, 1, "hold",    1'b1, 1'b0); endtask
    task automatic test_long();    run_seq(20, 10, "long",  1'b0, 1'b0); endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        test_reset();
        test_min();
        test_mid();
        test_clamp0();
        test_clamp1();
        test_disturb();
        test_hold();
        test_long();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule